// File: doc/BRIEF.md
# Cell Voltage Protection Controller

This block supervises a series stack of four to seven cells. For every cell it receives ideal comparator flags for the overcharge, overdischarge and balance thresholds and their release levels, plus a flag for the zero-volt recharge limit. It also receives a charger-present input and a load-present input. From these it drives a charge-inhibit output, a discharge-inhibit output and one balance-enable output per cell. It enters a low-power sleep state after an overdischarge and leaves it when a charger is present long enough.

All timing runs on a single tick-enable input. A free-running monitor period samples the flags. A detection condition counts for a period only when it holds across a detect window at the start of that period. A release condition must hold across a shorter release window. Each fault then needs a long run of qualified periods before it is flagged. A configuration input per fault type chooses the release rule. With voltage recovery, the fault clears once every active cell is past its release level. With latch, the charger or load must also be absent. A cell-count select removes the upper cells from every decision.

Top module: `cellguard_top`

## Requirements
- R1: `cell_sel` value k (0 to 3) makes the lowest 4+k cells active. Flags of inactive cells never raise a fault, never enable balancing and never block charging. Inactive cells count as released. `bal_en` of an inactive cell is 0 one cycle after it becomes inactive.
- R2: Let the monitor counter run from 0 to MON_PERIOD-1 on tick cycles. A cell's detection flag counts for a period only if it was 1 on each of the first DET_WIN ticks of that period. A release condition counts only if it held on each of the first REL_WIN ticks. Cycles with `tick_en`=0 advance no counter.
- R3: `ov_fault` sets after the sampled overcharge condition (`ovc_flag`=1 on any active cell) has persisted for OV_DELAY ticks. `chg_off` is 1 whenever `ov_fault` is 1. Every output is 0 after reset.
- R4: `uv_fault` sets after the sampled overdischarge condition (`uvd_flag`=1 on any active cell) has persisted for UV_DELAY ticks. `dsg_off` is 1 whenever `uv_fault` is 1.
- R5: A delay count that loses its condition before expiry restarts from zero.
- R6: In recovery mode (latch input 0), each fault clears once its sampled release holds on all active cells. For overcharge the release condition is `ovr_flag`=0; for overdischarge it is `uvr_flag`=0.
- R7: With `ov_latch_mode`=1, `ov_fault` clears only when the release holds and `chg_present`=0.
- R8: With `uv_latch_mode`=1, `uv_fault` clears only when the release holds and `load_present`=0.
- R9: `bal_en[i]` sets after `bal_flag[i]` has been 1 for BAL_DELAY ticks. It then stays set while `bal_hold_flag[i]`=1, even if `bal_flag[i]` falls, and it clears in the cycle after `bal_hold_flag[i]` is 0.
- R10: `psave` sets after PS_DELAY ticks during which all of the following hold: `uv_fault`=1, `chg_present`=0, and `uvr_flag`=1 on some active cell. `dsg_off` is 1 while `psave` is 1.
- R11: `psave` clears after `chg_present` has been 1 for WAKE_DELAY ticks. A shorter charger pulse leaves it set.
- R12: With `zero_v_block`=1, `chg_off` is 1 at once whenever any active cell has `lowv_flag`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Time-base tick; all delays count these cycles |
| cell_sel | input | 2 | Active cell count minus four |
| ovc_flag | input | MAX_CELLS | Cell above overcharge detect level |
| ovr_flag | input | MAX_CELLS | Cell above overcharge release level |
| uvd_flag | input | MAX_CELLS | Cell below overdischarge detect level |
| uvr_flag | input | MAX_CELLS | Cell below overdischarge release level |
| bal_flag | input | MAX_CELLS | Cell above balance threshold |
| bal_hold_flag | input | MAX_CELLS | Cell above balance release level |
| lowv_flag | input | MAX_CELLS | Cell below zero-volt recharge limit |
| chg_present | input | 1 | Charger connected |
| load_present | input | 1 | Load connected |
| ov_latch_mode | input | 1 | Overcharge release needs charger removal |
| uv_latch_mode | input | 1 | Overdischarge release needs load removal |
| zero_v_block | input | 1 | Prohibit charging of near-empty cells |
| chg_off | output | 1 | Charge inhibit |
| dsg_off | output | 1 | Discharge inhibit |
| bal_en | output | MAX_CELLS | Per-cell balance enable |
| psave | output | 1 | Low-power sleep state |
| ov_fault | output | 1 | Overcharge flagged |
| uv_fault | output | 1 | Overdischarge flagged |

## Verification
The assertions check several rules on every cycle. Balance enables never survive an inactive cell or a low hold flag. A latched fault never clears while its charger or load is present. Sleep is entered only from an overdischarge with no charger, and is left only with a charger present. Other behaviour depends on counted time, and only the bench scenarios can show it. That covers rejecting flags too short for the detect window, restarting interrupted delays, and pausing when ticks stop. It also covers the exact cycle where each fault, balance enable and sleep change. For these, a behavioural reference model is compared against the outputs on every clock.

// File: rtl/cellguard_pkg.sv
// Shared constants, types and helpers for the cell protection controller.
// Assumes the cell-count select is two bits wide and counts up from four cells.
package cellguard_pkg;

    localparam int MIN_CELLS = 4;
    localparam int SEL_W     = 2;

    // Sleep sequencer states.
    typedef enum logic {
        PS_AWAKE  = 1'b0,
        PS_ASLEEP = 1'b1
    } ps_state_t;

    // True when cell index idx takes part under select code sel.
    function automatic logic cell_active(input int idx, input logic [SEL_W-1:0] sel);
        return (idx < MIN_CELLS + int'(sel));
    endfunction

endpackage

// File: rtl/cg_scan.sv
// Monitor period generator.
// Counts tick cycles from 0 to PERIOD-1 and flags the tick that opens a period
// and the ticks that close the detect and release windows.
// Assumes 1 <= REL_WIN <= PERIOD, 1 <= DET_WIN <= PERIOD and PERIOD >= 2.
module cg_scan #(
    parameter int PERIOD  = 72,
    parameter int DET_WIN = 32,
    parameter int REL_WIN = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    output logic win_start,
    output logic det_end,
    output logic rel_end
);
    localparam int CNT_W = $clog2(PERIOD);
    localparam logic [CNT_W-1:0] LAST    = CNT_W'(PERIOD - 1);
    localparam logic [CNT_W-1:0] DET_TOP = CNT_W'(DET_WIN - 1);
    localparam logic [CNT_W-1:0] REL_TOP = CNT_W'(REL_WIN - 1);

    logic [CNT_W-1:0] mon_cnt;

    // Advance the position inside the monitor period on every tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mon_cnt <= '0;
        end else if (tick) begin
            mon_cnt <= (mon_cnt == LAST) ? '0 : mon_cnt + 1'b1;
        end
    end

    assign win_start = tick && (mon_cnt == '0);
    assign det_end   = tick && (mon_cnt == DET_TOP);
    assign rel_end   = tick && (mon_cnt == REL_TOP);

endmodule

// File: rtl/cg_window.sv
// Window sampler.
// ANDs a flag vector over every tick from the window opening to its closing
// tick, then holds the result until the same window closes in the next period.
// Assumes close only arrives on a tick cycle.
module cg_window #(
    parameter int W = 14
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         open_p,
    input  logic         close_p,
    input  logic [W-1:0] flags,
    output logic [W-1:0] held
);
    logic [W-1:0] acc;

    // Accumulate flags that stayed set since the window opened.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc <= '0;
        end else if (open_p) begin
            acc <= flags;
        end else if (tick) begin
            acc <= acc & flags;
        end
    end

    // Capture the window result when the window closes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held <= '0;
        end else if (close_p) begin
            held <= open_p ? flags : (acc & flags);
        end
    end

endmodule

// File: rtl/cg_qual.sv
// Delay qualifier.
// Counts ticks while cond holds, restarts at zero when cond drops, and reports
// done while cond holds and LIMIT ticks have been counted.
// Assumes LIMIT >= 1.
module cg_qual #(
    parameter int LIMIT = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic cond,
    output logic done
);
    localparam int CNT_W = $clog2(LIMIT + 1);
    localparam logic [CNT_W-1:0] LIM = CNT_W'(LIMIT);

    logic [CNT_W-1:0] cnt;

    // Count qualified ticks, saturating at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!cond) begin
            cnt <= '0;
        end else if (tick && (cnt != LIM)) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign done = cond && (cnt == LIM);

endmodule

// File: rtl/cg_fault.sv
// Fault latch with delayed entry and selectable release.
// Sets after the sampled detection has persisted DELAY ticks. Clears when the
// sampled release holds on every cell and, in latch mode, the remove input
// (charger or load present) is low.
// Assumes det_held and rel_held are already masked for inactive cells.
module cg_fault #(
    parameter int N     = 7,
    parameter int DELAY = 1024
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic [N-1:0] det_held,
    input  logic [N-1:0] rel_held,
    input  logic         latch_mode,
    input  logic         attached,
    output logic         fault
);
    logic arm_cond;
    logic arm_done;
    logic release_ok;

    assign arm_cond   = (|det_held) && !fault;
    assign release_ok = (&rel_held) && (!latch_mode || !attached);

    cg_qual #(.LIMIT(DELAY)) u_arm (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .cond  (arm_cond),
        .done  (arm_done)
    );

    // Hold the fault from qualified entry until an allowed release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fault <= 1'b0;
        end else if (!fault && arm_done) begin
            fault <= 1'b1;
        end else if (fault && release_ok) begin
            fault <= 1'b0;
        end
    end

endmodule

// File: rtl/cellguard_top.sv
// Cell voltage protection controller top.
// Samples per-cell comparator flags in monitor windows, qualifies overcharge
// and overdischarge with long delays, drives charge and discharge inhibits,
// runs per-cell balance with hysteresis and sequences the sleep state.
// Assumes all flags are synchronous to clk and that tick_en paces all timing.
module cellguard_top #(
    parameter int MAX_CELLS  = 7,
    parameter int MON_PERIOD = 72,
    parameter int DET_WIN    = 32,
    parameter int REL_WIN    = 8,
    parameter int OV_DELAY   = 1024,
    parameter int UV_DELAY   = 1024,
    parameter int BAL_DELAY  = 256,
    parameter int PS_DELAY   = 2048,
    parameter int WAKE_DELAY = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick_en,
    input  logic [1:0]           cell_sel,
    input  logic [MAX_CELLS-1:0] ovc_flag,
    input  logic [MAX_CELLS-1:0] ovr_flag,
    input  logic [MAX_CELLS-1:0] uvd_flag,
    input  logic [MAX_CELLS-1:0] uvr_flag,
    input  logic [MAX_CELLS-1:0] bal_flag,
    input  logic [MAX_CELLS-1:0] bal_hold_flag,
    input  logic [MAX_CELLS-1:0] lowv_flag,
    input  logic                 chg_present,
    input  logic                 load_present,
    input  logic                 ov_latch_mode,
    input  logic                 uv_latch_mode,
    input  logic                 zero_v_block,
    output logic                 chg_off,
    output logic                 dsg_off,
    output logic [MAX_CELLS-1:0] bal_en,
    output logic                 psave,
    output logic                 ov_fault,
    output logic                 uv_fault
);
    import cellguard_pkg::*;

    localparam int N = MAX_CELLS;

    logic [N-1:0]   act_mask;
    logic           win_start, det_end, rel_end;
    logic [2*N-1:0] det_in, det_held;
    logic [2*N-1:0] rel_in, rel_held;
    ps_state_t      ps_state;
    logic           ps_cond, ps_done, wake_cond, wake_done;

    // Active-cell mask from the cell-count select.
    generate
        for (genvar i = 0; i < N; i++) begin : g_mask
            assign act_mask[i] = cell_active(i, cell_sel);
        end
    endgenerate

    // Masked detection and release conditions, overcharge in the low half.
    assign det_in = {uvd_flag & act_mask, ovc_flag & act_mask};
    assign rel_in = {~uvr_flag | ~act_mask, ~ovr_flag | ~act_mask};

    cg_scan #(
        .PERIOD  (MON_PERIOD),
        .DET_WIN (DET_WIN),
        .REL_WIN (REL_WIN)
    ) u_scan (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick_en),
        .win_start (win_start),
        .det_end   (det_end),
        .rel_end   (rel_end)
    );

    cg_window #(.W(2 * N)) u_det_win (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick_en),
        .open_p  (win_start),
        .close_p (det_end),
        .flags   (det_in),
        .held    (det_held)
    );

    cg_window #(.W(2 * N)) u_rel_win (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick_en),
        .open_p  (win_start),
        .close_p (rel_end),
        .flags   (rel_in),
        .held    (rel_held)
    );

    cg_fault #(.N(N), .DELAY(OV_DELAY)) u_ov (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick_en),
        .det_held   (det_held[N-1:0]),
        .rel_held   (rel_held[N-1:0]),
        .latch_mode (ov_latch_mode),
        .attached   (chg_present),
        .fault      (ov_fault)
    );

    cg_fault #(.N(N), .DELAY(UV_DELAY)) u_uv (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick_en),
        .det_held   (det_held[2*N-1:N]),
        .rel_held   (rel_held[2*N-1:N]),
        .latch_mode (uv_latch_mode),
        .attached   (load_present),
        .fault      (uv_fault)
    );

    // Per-cell balance: delayed entry, release on the lower hold level.
    generate
        for (genvar i = 0; i < N; i++) begin : g_bal
            logic arm;
            logic armed;
            logic en_r;

            assign arm = bal_flag[i] && act_mask[i];

            cg_qual #(.LIMIT(BAL_DELAY)) u_bal_q (
                .clk   (clk),
                .rst_n (rst_n),
                .tick  (tick_en),
                .cond  (arm),
                .done  (armed)
            );

            // Set after the balance delay, drop below the hold level or when unused.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    en_r <= 1'b0;
                end else if (!act_mask[i] || !bal_hold_flag[i]) begin
                    en_r <= 1'b0;
                end else if (armed) begin
                    en_r <= 1'b1;
                end
            end

            assign bal_en[i] = en_r;
        end
    endgenerate

    // Sleep entry and wake conditions.
    assign ps_cond   = uv_fault && !chg_present && (|(uvr_flag & act_mask))
                       && (ps_state == PS_AWAKE);
    assign wake_cond = (ps_state == PS_ASLEEP) && chg_present;

    cg_qual #(.LIMIT(PS_DELAY)) u_ps_q (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick_en),
        .cond  (ps_cond),
        .done  (ps_done)
    );

    cg_qual #(.LIMIT(WAKE_DELAY)) u_wake_q (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick_en),
        .cond  (wake_cond),
        .done  (wake_done)
    );

    // Sleep sequencer: enter after the sleep delay, leave after a qualified wake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ps_state <= PS_AWAKE;
        end else begin
            case (ps_state)
                PS_AWAKE:  if (ps_done)   ps_state <= PS_ASLEEP;
                PS_ASLEEP: if (wake_done) ps_state <= PS_AWAKE;
                default:   ps_state <= PS_AWAKE;
            endcase
        end
    end

    assign psave   = (ps_state == PS_ASLEEP);
    assign chg_off = ov_fault || (zero_v_block && (|(lowv_flag & act_mask)));
    assign dsg_off = uv_fault || psave;

endmodule

// File: rtl/cellguard_chk.sv
// Assertion checker for cellguard_top, attached by bind.
// Assumes reset is asserted from time zero.
module cellguard_chk #(
    parameter int MAX_CELLS = 7
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [1:0]           cell_sel,
    input logic [MAX_CELLS-1:0] bal_hold_flag,
    input logic                 chg_present,
    input logic                 load_present,
    input logic                 ov_latch_mode,
    input logic                 uv_latch_mode,
    input logic                 ov_fault,
    input logic                 uv_fault,
    input logic                 psave,
    input logic [MAX_CELLS-1:0] bal_en
);
    logic [MAX_CELLS-1:0] mask;

    // Recompute the active-cell mask from the select port.
    always_comb begin
        for (int i = 0; i < MAX_CELLS; i++) begin
            mask[i] = cellguard_pkg::cell_active(i, cell_sel);
        end
    end

    AST_BAL_UNUSED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        ((bal_en & ~$past(mask)) == '0));  // R1

    AST_BAL_HOLD_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        ((bal_en & ~$past(bal_hold_flag)) == '0));  // R9

    AST_OV_LATCH_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ov_fault) && $past(ov_latch_mode)) |-> !$past(chg_present));  // R7

    AST_UV_LATCH_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(uv_fault) && $past(uv_latch_mode)) |-> !$past(load_present));  // R8

    AST_PS_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(psave) |-> ($past(uv_fault) && !$past(chg_present)));  // R10

    AST_PS_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(psave) |-> $past(chg_present));  // R11

endmodule

bind cellguard_top cellguard_chk #(.MAX_CELLS(MAX_CELLS)) u_chk (.*);

// File: tb/cellguard_top_tb.sv
// Bench for cellguard_top: a behavioural reference model compared every clock,
// plus directed scenarios with hand-derived expectations.
module cellguard_top_tb;
    localparam int N    = 7;
    localparam int MON  = 12;
    localparam int DETW = 4;
    localparam int RELW = 2;
    localparam int OVD  = 20;
    localparam int UVD  = 20;
    localparam int BALD = 6;
    localparam int PSD  = 30;
    localparam int WKD  = 3;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_n = 1'b0;
    logic tick_en = 1'b1;
    logic [1:0] cell_sel = 2'd3;
    logic [N-1:0] ovc_flag = '0, ovr_flag = '0, uvd_flag = '0, uvr_flag = '0;
    logic [N-1:0] bal_flag = '0, bal_hold_flag = '0, lowv_flag = '0;
    logic chg_present = 0, load_present = 0, ov_latch_mode = 0, uv_latch_mode = 0;
    logic zero_v_block = 0;
    logic chg_off, dsg_off, psave, ov_fault, uv_fault;
    logic [N-1:0] bal_en;

    int checks = 0;
    int fails = 0;
    bit done_flag = 0;

    cellguard_top #(
        .MAX_CELLS(N), .MON_PERIOD(MON), .DET_WIN(DETW), .REL_WIN(RELW),
        .OV_DELAY(OVD), .UV_DELAY(UVD), .BAL_DELAY(BALD),
        .PS_DELAY(PSD), .WAKE_DELAY(WKD)
    ) u_dut (.*);

    // Reference model state.
    int m_pos;
    bit [N-1:0] m_dacc_ov, m_dacc_uv, m_dh_ov, m_dh_uv;
    bit [N-1:0] m_racc_ov, m_racc_uv, m_rh_ov, m_rh_uv;
    int m_ovq, m_uvq, m_psq, m_wkq;
    int m_balq[N];
    bit m_ovf, m_uvf, m_ps;
    bit [N-1:0] m_bal;

    function automatic bit [N-1:0] active_cells(input logic [1:0] sel);
        bit [N-1:0] a;
        for (int i = 0; i < N; i++) a[i] = (i < 4 + int'(sel));
        return a;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference model update at each rising edge, from pre-edge inputs and state.
    always @(posedge clk) begin : model
        bit [N-1:0] a, dov, duv, rov, ruv;
        bit tk, st, de, re, cond, dn, rok, old_uvf, old_ovf, pc, wc;
        if (!rst_n) begin
            m_pos = 0; m_dacc_ov = 0; m_dacc_uv = 0; m_dh_ov = 0; m_dh_uv = 0;
            m_racc_ov = 0; m_racc_uv = 0; m_rh_ov = 0; m_rh_uv = 0;
            m_ovq = 0; m_uvq = 0; m_psq = 0; m_wkq = 0;
            m_ovf = 0; m_uvf = 0; m_ps = 0; m_bal = 0;
            for (int i = 0; i < N; i++) m_balq[i] = 0;
        end else begin
            a = active_cells(cell_sel);
            tk = tick_en;
            old_uvf = m_uvf;
            old_ovf = m_ovf;
            // overcharge fault
            cond = (|m_dh_ov) && !old_ovf;
            dn = cond && (m_ovq == OVD);
            rok = (&m_rh_ov) && (!ov_latch_mode || !chg_present);
            if (!old_ovf && dn) m_ovf = 1; else if (old_ovf && rok) m_ovf = 0;
            if (!cond) m_ovq = 0; else if (tk && m_ovq != OVD) m_ovq++;
            // overdischarge fault
            cond = (|m_dh_uv) && !old_uvf;
            dn = cond && (m_uvq == UVD);
            rok = (&m_rh_uv) && (!uv_latch_mode || !load_present);
            if (!old_uvf && dn) m_uvf = 1; else if (old_uvf && rok) m_uvf = 0;
            if (!cond) m_uvq = 0; else if (tk && m_uvq != UVD) m_uvq++;
            // balance
            for (int i = 0; i < N; i++) begin
                cond = bal_flag[i] && a[i];
                dn = cond && (m_balq[i] == BALD);
                if (!a[i] || !bal_hold_flag[i]) m_bal[i] = 0; else if (dn) m_bal[i] = 1;
                if (!cond) m_balq[i] = 0; else if (tk && m_balq[i] != BALD) m_balq[i]++;
            end
            // sleep
            pc = old_uvf && !chg_present && (|(uvr_flag & a)) && !m_ps;
            wc = m_ps && chg_present;
            if (!m_ps && pc && m_psq == PSD) m_ps = 1;
            else if (m_ps && wc && m_wkq == WKD) m_ps = 0;
            if (!pc) m_psq = 0; else if (tk && m_psq != PSD) m_psq++;
            if (!wc) m_wkq = 0; else if (tk && m_wkq != WKD) m_wkq++;
            // windows
            st = tk && (m_pos == 0);
            de = tk && (m_pos == DETW - 1);
            re = tk && (m_pos == RELW - 1);
            dov = ovc_flag & a; duv = uvd_flag & a;
            rov = ~ovr_flag | ~a; ruv = ~uvr_flag | ~a;
            if (de) begin
                m_dh_ov = st ? dov : (m_dacc_ov & dov);
                m_dh_uv = st ? duv : (m_dacc_uv & duv);
            end
            if (re) begin
                m_rh_ov = st ? rov : (m_racc_ov & rov);
                m_rh_uv = st ? ruv : (m_racc_uv & ruv);
            end
            if (st) begin
                m_dacc_ov = dov; m_dacc_uv = duv; m_racc_ov = rov; m_racc_uv = ruv;
            end else if (tk) begin
                m_dacc_ov &= dov; m_dacc_uv &= duv; m_racc_ov &= rov; m_racc_uv &= ruv;
            end
            if (tk) m_pos = (m_pos == MON - 1) ? 0 : m_pos + 1;
        end
    end

    // Compare outputs with the model a quarter period after each edge.
    always @(posedge clk) begin
        #5;
        if (!done_flag) begin
            chk("R3 ov_fault model", ov_fault, m_ovf);
            chk("R4 uv_fault model", uv_fault, m_uvf);
            chk("R12 chg_off model", chg_off,
                m_ovf | (zero_v_block & (|(lowv_flag & active_cells(cell_sel)))));
            chk("R10 dsg_off model", dsg_off, m_uvf | m_ps);
            chk("R9 bal_en model", bal_en, m_bal);
            chk("R11 psave model", psave, m_ps);
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        done_flag = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // Watchdog.
    initial begin
        #(100000 * 20);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        cyc(5);
        rst_n = 1;
        cyc(2);
        chk("R3 reset chg_off", chg_off, 0);
        chk("R4 reset dsg_off", dsg_off, 0);
        chk("R10 reset psave", psave, 0);
        chk("R9 reset bal_en", bal_en, 0);

        // R3 overcharge entry and R6 recovery release
        ovc_flag[0] = 1; ovr_flag[0] = 1;
        cyc(10);
        chk("R3 not yet flagged", ov_fault, 0);
        cyc(90);
        chk("R3 ov_fault set", ov_fault, 1);
        chk("R3 chg_off set", chg_off, 1);
        ovc_flag[0] = 0;
        cyc(40);
        chk("R6 ov held while above release", ov_fault, 1);
        ovr_flag[0] = 0;
        cyc(40);
        chk("R6 ov recovered", ov_fault, 0);

        // R5 restart: condition sampled in alternate periods only
        ovr_flag[0] = 1;
        for (int k = 0; k < 8; k++) begin
            ovc_flag[0] = 1; cyc(12);
            ovc_flag[0] = 0; cyc(12);
        end
        chk("R5 interrupted delay restarts", ov_fault, 0);

        // R2 glitch shorter than the detect window
        for (int k = 0; k < 16; k++) begin
            ovc_flag[0] = 1; cyc(3);
            ovc_flag[0] = 0; cyc(9);
        end
        chk("R2 short flag ignored", ov_fault, 0);
        ovr_flag[0] = 0;

        // R2 tick gating
        tick_en = 0;
        ovc_flag[0] = 1; ovr_flag[0] = 1;
        cyc(200);
        chk("R2 no ticks no fault", ov_fault, 0);
        for (int k = 0; k < 150; k++) begin
            tick_en = 1; cyc(1);
            tick_en = 0; cyc(1);
        end
        tick_en = 1;
        chk("R2 sparse ticks reach fault", ov_fault, 1);
        ovc_flag[0] = 0; ovr_flag[0] = 0;
        cyc(40);
        chk("R6 ov recovered after sparse ticks", ov_fault, 0);

        // R1 masking of upper cells
        cell_sel = 2'd0;
        ovc_flag[6] = 1; ovr_flag[6] = 1; bal_flag[6] = 1; bal_hold_flag[6] = 1;
        cyc(100);
        chk("R1 unused cell no fault", ov_fault, 0);
        chk("R1 unused cell no balance", bal_en, 0);
        cell_sel = 2'd3;
        cyc(100);
        chk("R1 seven cells fault", ov_fault, 1);
        chk("R1 seven cells balance", bal_en, 7'b1000000);
        cell_sel = 2'd2;
        cyc(2);
        chk("R1 balance drops when cell unused", bal_en, 0);
        cyc(40);
        chk("R1 unused cell counts as released", ov_fault, 0);
        cell_sel = 2'd3;
        ovc_flag[6] = 0; ovr_flag[6] = 0; bal_flag[6] = 0; bal_hold_flag[6] = 0;
        cyc(40);

        // R9 balance with hysteresis
        bal_flag[2] = 1; bal_hold_flag[2] = 1;
        cyc(4);
        chk("R9 balance waits for delay", bal_en[2], 0);
        cyc(16);
        chk("R9 balance set", bal_en[2], 1);
        bal_flag[2] = 0;
        cyc(10);
        chk("R9 balance held above hold level", bal_en[2], 1);
        bal_hold_flag[2] = 0;
        cyc(2);
        chk("R9 balance released", bal_en[2], 0);
        bal_hold_flag[2] = 1;
        for (int k = 0; k < 5; k++) begin
            bal_flag[2] = 1; cyc(4);
            bal_flag[2] = 0; cyc(2);
        end
        chk("R5 balance restarts on drop", bal_en[2], 0);
        bal_hold_flag[2] = 0;

        // R7 overcharge latch
        ov_latch_mode = 1; chg_present = 1;
        ovc_flag[1] = 1; ovr_flag[1] = 1;
        cyc(100);
        chk("R7 latched ov set", ov_fault, 1);
        ovc_flag[1] = 0; ovr_flag[1] = 0;
        cyc(60);
        chk("R7 ov held with charger", ov_fault, 1);
        chg_present = 0;
        cyc(5);
        chk("R7 ov clears on charger removal", ov_fault, 0);
        ov_latch_mode = 0;

        // R8 overdischarge latch (charger present keeps sleep away)
        uv_latch_mode = 1; load_present = 1; chg_present = 1;
        uvd_flag[3] = 1; uvr_flag[3] = 1;
        cyc(100);
        chk("R4 uv_fault set", uv_fault, 1);
        chk("R4 dsg_off set", dsg_off, 1);
        uvd_flag[3] = 0; uvr_flag[3] = 0;
        cyc(60);
        chk("R8 uv held with load", uv_fault, 1);
        load_present = 0;
        cyc(5);
        chk("R8 uv clears on load removal", uv_fault, 0);
        uv_latch_mode = 0;

        // R6 overdischarge recovery
        uvd_flag[0] = 1; uvr_flag[0] = 1;
        cyc(100);
        chk("R4 uv set cell0", uv_fault, 1);
        uvd_flag[0] = 0; uvr_flag[0] = 0;
        cyc(40);
        chk("R6 uv recovered", uv_fault, 0);
        chg_present = 0;

        // R10 sleep entry
        uvd_flag[5] = 1; uvr_flag[5] = 1;
        cyc(200);
        chk("R10 psave entered", psave, 1);
        chk("R10 dsg_off in sleep", dsg_off, 1);
        uvd_flag[5] = 0;
        cyc(40);
        chk("R6 uv held below release level", uv_fault, 1);
        // R11 wake qualification
        chg_present = 1; cyc(2);
        chg_present = 0; cyc(10);
        chk("R11 short charger pulse keeps sleep", psave, 1);
        chg_present = 1;
        cyc(10);
        chk("R11 wake after delay", psave, 0);
        uvr_flag[5] = 0;
        cyc(40);
        chk("R6 uv recovered after wake", uv_fault, 0);
        chk("R4 dsg_off released", dsg_off, 0);
        chg_present = 0;

        // R12 zero-volt charge block
        zero_v_block = 1; lowv_flag[1] = 1;
        cyc(1);
        chk("R12 chg_off near-empty cell", chg_off, 1);
        lowv_flag = 7'b0100000; cell_sel = 2'd0;
        cyc(1);
        chk("R12 unused near-empty cell ignored", chg_off, 0);
        cell_sel = 2'd3;
        cyc(1);
        chk("R12 active near-empty cell blocks", chg_off, 1);
        zero_v_block = 0;
        cyc(1);
        chk("R12 block disabled", chg_off, 0);
        lowv_flag = '0;
        cyc(5);

        finish_run();
    end

endmodule